// File: doc/BRIEF.md
# AHB-Lite Protection Checker for a Non-Volatile Memory Port

This block sits in the address path between an AHB-Lite slave port and an embedded non-volatile memory with its control register window. It decodes every transfer the moment its address phase is accepted. It then does one of three things with it:

- **Forward:** pass the transfer unchanged to the memory side.
- **Reject:** answer it locally with an AHB-Lite error response.
- **Swallow:** answer a write to a read-only control register locally with OKAY, so the memory never sees it.

Transfers are rejected for four reasons:

- the bus writes into the user data array;
- the access hits a special sector whose read or write protection is set;
- a master other than the privileged one touches a private region;
- a read burst loses its incrementing or wrapping address sequence, or is cut short before its planned beat count.

Special sector protection arrives on static configuration inputs. The identity of the issuing master arrives on a sideband input that is sampled together with the address. The memory array itself, program and erase sequencing, and lock storage all live elsewhere.

Top module: `ahb_nvm_guard`

## Requirements
- R1: A write that falls inside the data array (addresses below ARRAY_BYTES) from any master whose id differs from PRIV_ID gets an error response. The privileged master may write the array, subject to R2.
- R2: There are NSEC special sectors (2 or 4), each 4 KB, with one read-protect bit and one write-protect bit each. Bit i of `cfg_rd_prot` blocks reads of sector i, and bit i of `cfg_wr_prot` blocks writes. Sectors below NSEC/2 start at address i*4 KB. Sector NSEC-1 always covers the highest 4 KB of the array, and with four sectors, sector 2 covers the 4 KB just below it. A blocked access gets an error response; with the bit clear the access is forwarded.
- R3: The two private regions (PRIV0_BASE and PRIV1_BASE, each PRIV_BYTES long) return an error for any read or write whose `s_hmaster` differs from PRIV_ID. The privileged master is forwarded. Addresses just outside a region are not affected.
- R4: Burst address sequence (reads only):
  - After a read NONSEQ with a burst code other than SINGLE (0), every SEQ read must carry the previous address plus 2^HSIZE.
  - For the wrapping codes 2, 4 and 6, the address wraps inside a (beats × 2^HSIZE)-byte aligned block.
  - A SEQ beat that breaks the sequence, or a SEQ read outside a burst, gets an error.
- R5: Early termination of a fixed-length read burst (codes 2 to 7; 4, 8 or 16 beats):
  - A NONSEQ issued before the burst's last beat gets an error.
  - An IDLE, or a deselected cycle, before the last beat makes the next NONSEQ get an error.
  - BUSY is allowed between beats.
  - An undefined-length burst (code 1) may end at any beat.
- R6: Every locally generated error takes two cycles: HREADYOUT low with HRESP high, then HREADYOUT high with HRESP high. Read data is zero throughout the error response.
- R7: A write to a read-only control register (CTRL_BASE+RO_OFF0 or CTRL_BASE+RO_OFF1) completes with a zero-wait OKAY and is not forwarded, so the register cannot change. Reads of those registers are forwarded.
- R8: A transfer that is neither rejected nor swallowed appears on the memory side in the same cycle with its address, direction, size and burst unchanged. The memory side's read data and response are returned to the master. A rejected or swallowed transfer leaves the memory side's HTRANS at IDLE.
- R9: During reset, and in the data phase after an IDLE, BUSY or deselected cycle, the port shows HREADYOUT high and HRESP low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rd_prot | input | NSEC | Per-sector read protect |
| cfg_wr_prot | input | NSEC | Per-sector write protect |
| s_hsel | input | 1 | Slave select |
| s_haddr | input | AW | Address |
| s_htrans | input | 2 | Transfer type |
| s_hwrite | input | 1 | Write when high |
| s_hsize | input | 3 | Transfer size |
| s_hburst | input | 3 | Burst code |
| s_hwdata | input | DW | Write data |
| s_hready | input | 1 | Bus ready (address phase sample point) |
| s_hmaster | input | MW | Issuing master id, sampled with the address |
| s_hreadyout | output | 1 | Ready towards the bus |
| s_hresp | output | 1 | Error response towards the bus |
| s_hrdata | output | DW | Read data towards the bus |
| m_hsel | output | 1 | Select to the memory side |
| m_haddr | output | AW | Address to the memory side |
| m_htrans | output | 2 | Filtered transfer type |
| m_hwrite | output | 1 | Direction to the memory side |
| m_hsize | output | 3 | Size to the memory side |
| m_hburst | output | 3 | Burst code to the memory side |
| m_hwdata | output | DW | Write data to the memory side |
| m_hready | output | 1 | Bus ready to the memory side |
| m_hreadyout | input | 1 | Memory side ready |
| m_hresp | input | 1 | Memory side error response |
| m_hrdata | input | DW | Memory side read data |

## Verification
The embedded properties check the following on every cycle:

- the shape of the two-cycle error and its zero read data;
- that an unprivileged private-region access is never forwarded;
- that array writes by ordinary masters are rejected;
- that read-only register writes finish as OKAY;
- that sequence breaks and premature NONSEQs lead to an error;
- that idle cycles answer zero-wait OKAY.

The following are visible only through the bench's scenarios:

- the sector placement at the top of the array and the effect of each configuration bit;
- the exact private-region boundaries;
- wrapping address arithmetic;
- the deferred error after an IDLE that cuts a burst;
- recovery on the next transfer;
- the data returned by forwarded reads.

// File: rtl/ahb_nvm_guard.sv
module ahb_nvm_guard #(
  parameter int          AW          = 20,
  parameter int          DW          = 32,
  parameter int          MW          = 2,
  parameter int          NSEC        = 4,
  parameter int unsigned ARRAY_BYTES = 32'h0001_0000,
  parameter int unsigned SEC_BYTES   = 32'h0000_1000,
  parameter int unsigned PRIV0_BASE  = 32'h0000_8000,
  parameter int unsigned PRIV1_BASE  = 32'h0000_9000,
  parameter int unsigned PRIV_BYTES  = 32'h0000_1000,
  parameter int unsigned PRIV_ID     = 3,
  parameter int unsigned CTRL_BASE   = 32'h0008_0000,
  parameter int unsigned CTRL_BYTES  = 32'h0000_0200,
  parameter int unsigned RO_OFF0     = 32'h0000_0100,
  parameter int unsigned RO_OFF1     = 32'h0000_0104
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSEC-1:0] cfg_rd_prot,
  input  logic [NSEC-1:0] cfg_wr_prot,
  input  logic            s_hsel,
  input  logic [AW-1:0]   s_haddr,
  input  logic [1:0]      s_htrans,
  input  logic            s_hwrite,
  input  logic [2:0]      s_hsize,
  input  logic [2:0]      s_hburst,
  input  logic [DW-1:0]   s_hwdata,
  input  logic            s_hready,
  input  logic [MW-1:0]   s_hmaster,
  output logic            s_hreadyout,
  output logic            s_hresp,
  output logic [DW-1:0]   s_hrdata,
  output logic            m_hsel,
  output logic [AW-1:0]   m_haddr,
  output logic [1:0]      m_htrans,
  output logic            m_hwrite,
  output logic [2:0]      m_hsize,
  output logic [2:0]      m_hburst,
  output logic [DW-1:0]   m_hwdata,
  output logic            m_hready,
  input  logic            m_hreadyout,
  input  logic            m_hresp,
  input  logic [DW-1:0]   m_hrdata
);

  localparam logic [1:0] T_IDLE = 2'b00;
  localparam logic [1:0] T_BUSY = 2'b01;
  localparam logic [1:0] T_NSEQ = 2'b10;
  localparam logic [1:0] T_SEQ  = 2'b11;
  localparam int         NLOW   = NSEC / 2;
  localparam logic [MW-1:0] PRIV_MID = MW'(PRIV_ID);
  localparam int unsigned RO_ADDR0 = CTRL_BASE + RO_OFF0;
  localparam int unsigned RO_ADDR1 = CTRL_BASE + RO_OFF1;

  typedef enum logic [2:0] {DP_NONE, DP_FWD, DP_SUP, DP_ERR1, DP_ERR2} dph_t;

  function automatic logic [AW-1:0] nxt_addr(input logic [AW-1:0] a, input logic [2:0] sz,
                                             input logic wrp, input logic [3:0] bm1);
    logic [AW-1:0] inc;
    logic [AW-1:0] msk;
    inc = AW'(1) << sz;
    msk = ((AW'(bm1) + AW'(1)) << sz) - AW'(1);
    return wrp ? ((a & ~msk) | ((a + inc) & msk)) : (a + inc);
  endfunction

  dph_t          dph;
  logic          bst_act, bst_fix, bst_wrap, term_pend;
  logic [2:0]    bst_sz;
  logic [3:0]    bst_bm1, bst_left;
  logic [AW-1:0] bst_exp;

  logic [31:0]     a32;
  logic [NSEC-1:0] sec_hit;
  logic            acc, is_nseq, is_seq, is_busy, priv;
  logic            in_arr, in_priv, in_ctrl, ro_reg;
  logic            sec_err, prot_err, term_err, seq_err, err, sup, fwd;
  logic [3:0]      new_bm1;
  logic            new_wrap;

  assign a32     = 32'(s_haddr);
  assign acc     = s_hsel && s_hready && s_htrans[1];
  assign is_nseq = acc && (s_htrans == T_NSEQ);
  assign is_seq  = acc && (s_htrans == T_SEQ);
  assign is_busy = s_hsel && (s_htrans == T_BUSY);
  assign priv    = (s_hmaster == PRIV_MID);

  for (genvar i = 0; i < NSEC; i++) begin : g_sec
    localparam int unsigned SB = (i < NLOW) ? i * SEC_BYTES
                                            : ARRAY_BYTES - (NSEC - i) * SEC_BYTES;
    assign sec_hit[i] = (a32 >= SB) && (a32 < SB + SEC_BYTES);
  end

  assign in_arr  = a32 < ARRAY_BYTES;
  assign in_priv = ((a32 >= PRIV0_BASE) && (a32 < PRIV0_BASE + PRIV_BYTES)) ||
                   ((a32 >= PRIV1_BASE) && (a32 < PRIV1_BASE + PRIV_BYTES));
  assign in_ctrl = (a32 >= CTRL_BASE) && (a32 < CTRL_BASE + CTRL_BYTES);
  assign ro_reg  = in_ctrl && ((a32 == RO_ADDR0) || (a32 == RO_ADDR1));

  assign sec_err  = |(sec_hit & (s_hwrite ? cfg_wr_prot : cfg_rd_prot));
  assign prot_err = sec_err || (in_priv && !priv) || (in_arr && s_hwrite && !priv);
  assign term_err = is_nseq && (term_pend || (bst_act && bst_fix));
  assign seq_err  = is_seq && (s_hwrite ? bst_act : (!bst_act || (s_haddr != bst_exp)));
  assign err      = acc && (prot_err || term_err || seq_err);
  assign sup      = acc && !err && s_hwrite && ro_reg;
  assign fwd      = acc && !err && !sup;

  assign new_bm1  = (s_hburst[2:1] == 2'b11) ? 4'd15 : (s_hburst[2:1] == 2'b10) ? 4'd7 : 4'd3;
  assign new_wrap = (s_hburst != 3'd0) && !s_hburst[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst_act   <= 1'b0;
      bst_fix   <= 1'b0;
      bst_wrap  <= 1'b0;
      bst_sz    <= '0;
      bst_bm1   <= '0;
      bst_left  <= '0;
      bst_exp   <= '0;
      term_pend <= 1'b0;
    end else if (s_hready) begin
      if (is_nseq) begin
        term_pend <= 1'b0;
        if (!err && !s_hwrite && (s_hburst != 3'd0)) begin
          bst_act  <= 1'b1;
          bst_fix  <= (s_hburst != 3'd1);
          bst_wrap <= new_wrap;
          bst_sz   <= s_hsize;
          bst_bm1  <= new_bm1;
          bst_left <= new_bm1;
          bst_exp  <= nxt_addr(s_haddr, s_hsize, new_wrap, new_bm1);
        end else begin
          bst_act <= 1'b0;
        end
      end else if (is_seq) begin
        if (err) begin
          bst_act <= 1'b0;
        end else if (bst_act) begin
          bst_exp <= nxt_addr(s_haddr, bst_sz, bst_wrap, bst_bm1);
          if (bst_fix) begin
            bst_left <= bst_left - 4'd1;
            if (bst_left == 4'd1) bst_act <= 1'b0;
          end
        end
      end else if (!is_busy) begin
        if (bst_act && bst_fix) term_pend <= 1'b1;
        bst_act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              dph <= DP_NONE;
    else if (dph == DP_ERR1) dph <= DP_ERR2;
    else if (s_hready)       dph <= err ? DP_ERR1 : sup ? DP_SUP : fwd ? DP_FWD : DP_NONE;
  end

  assign s_hreadyout = (dph == DP_ERR1) ? 1'b0 : (dph == DP_FWD) ? m_hreadyout : 1'b1;
  assign s_hresp     = (dph == DP_ERR1) || (dph == DP_ERR2) || ((dph == DP_FWD) && m_hresp);
  assign s_hrdata    = ((dph == DP_FWD) && !m_hresp) ? m_hrdata : '0;

  assign m_hsel   = s_hsel;
  assign m_haddr  = s_haddr;
  assign m_htrans = fwd ? s_htrans : (is_busy && bst_act) ? T_BUSY : T_IDLE;
  assign m_hwrite = s_hwrite;
  assign m_hsize  = s_hsize;
  assign m_hburst = s_hburst;
  assign m_hwdata = s_hwdata;
  assign m_hready = s_hready;

  p_err_two_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hresp && !s_hreadyout) |=> (s_hresp && s_hreadyout));
  p_err_data_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_hresp |-> (s_hrdata == '0));
  p_user_array_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && s_hwrite && in_arr && !priv) |=> (s_hresp && !s_hreadyout));
  p_private_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_priv && !priv) |-> (m_htrans == T_IDLE));
  p_ro_wr_okay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_nseq && s_hwrite && ro_reg && !term_pend && !bst_act) |=> (s_hreadyout && !s_hresp));
  p_seq_break_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_seq && !s_hwrite && bst_act && (s_haddr != bst_exp)) |=> s_hresp);
  p_nseq_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_nseq && bst_act && bst_fix) |=> s_hresp);
  p_idle_okay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hready && !(s_hsel && s_htrans[1])) |=> (s_hreadyout && !s_hresp));

endmodule

// File: tb/sim_ahb_nvm_guard.sv
`timescale 1ns/1ps
module sim_ahb_nvm_guard;
  localparam logic [1:0] IDLE = 2'b00, BUSY = 2'b01, NSEQ = 2'b10, SEQ = 2'b11;
  localparam logic [31:0] MIX = 32'h5A00_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_rd = 4'b1001, cfg_wr = 4'b0100;
  logic        hsel = 1'b0, hwrite = 1'b0;
  logic [19:0] haddr = '0;
  logic [1:0]  htrans = IDLE;
  logic [2:0]  hsize = 3'd2, hburst = 3'd0;
  logic [1:0]  hmaster = 2'd0;
  logic [31:0] hwdata = 32'h1234_5678;
  logic        hreadyout, hresp;
  logic [31:0] hrdata;
  logic        m_hsel, m_hwrite, m_hready;
  logic [19:0] m_haddr;
  logic [1:0]  m_htrans;
  logic [2:0]  m_hsize, m_hburst;
  logic [31:0] m_hwdata;
  logic [31:0] dq = '0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ahb_nvm_guard u0 (
    .clk(clk), .rst_n(rst_n), .cfg_rd_prot(cfg_rd), .cfg_wr_prot(cfg_wr),
    .s_hsel(hsel), .s_haddr(haddr), .s_htrans(htrans), .s_hwrite(hwrite),
    .s_hsize(hsize), .s_hburst(hburst), .s_hwdata(hwdata), .s_hready(hreadyout),
    .s_hmaster(hmaster), .s_hreadyout(hreadyout), .s_hresp(hresp), .s_hrdata(hrdata),
    .m_hsel(m_hsel), .m_haddr(m_haddr), .m_htrans(m_htrans), .m_hwrite(m_hwrite),
    .m_hsize(m_hsize), .m_hburst(m_hburst), .m_hwdata(m_hwdata), .m_hready(m_hready),
    .m_hreadyout(1'b1), .m_hresp(1'b0), .m_hrdata(dq));

  always_ff @(posedge clk)
    if (m_hsel && m_hready && m_htrans[1]) dq <= 32'(m_haddr) ^ MIX;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic xfer(input logic [1:0] tr, input logic wr, input logic [2:0] bu,
                      input logic [19:0] a, input logic [1:0] mid, input logic [1:0] gap,
                      output logic err, output logic [31:0] rd, output logic fwd);
    logic [31:0] z;
    @(negedge clk);
    hsel = 1'b1; htrans = tr; hwrite = wr; hsize = 3'd2; hburst = bu; haddr = a; hmaster = mid;
    #1 fwd = m_htrans[1];
    @(negedge clk);
    htrans = gap;
    #1;
    if (!hreadyout) begin
      err = hresp;
      z = hrdata;
      @(negedge clk);
      #1;
      err = err & hresp & hreadyout;
      rd = z | hrdata;
    end else begin
      check("R6 single-cycle error", {31'd0, hresp}, 32'd0);
      err = 1'b0;
      rd = hrdata;
    end
  endtask

  // {req[3:0], wr, mid[1:0], addr[19:0], exp_err, exp_fwd}
  localparam int NV = 17;
  localparam logic [28:0] VEC [NV] = '{
    {4'd8, 1'b0, 2'd0, 20'h04000, 1'b0, 1'b1},  // R8 plain read
    {4'd1, 1'b1, 2'd0, 20'h04000, 1'b1, 1'b0},  // R1 user write to array
    {4'd2, 1'b0, 2'd0, 20'h00010, 1'b1, 1'b0},  // R2 sector 0 read-protected
    {4'd2, 1'b0, 2'd0, 20'h01010, 1'b0, 1'b1},  // R2 sector 1 open
    {4'd2, 1'b0, 2'd0, 20'h0F000, 1'b1, 1'b0},  // R2 top 4 KB sector
    {4'd2, 1'b0, 2'd0, 20'h0EFFC, 1'b0, 1'b1},  // R2 sector 2 read open
    {4'd2, 1'b1, 2'd3, 20'h0E000, 1'b1, 1'b0},  // R2 sector 2 write-protected
    {4'd1, 1'b1, 2'd3, 20'h05000, 1'b0, 1'b1},  // R1 privileged array write
    {4'd3, 1'b0, 2'd0, 20'h08000, 1'b1, 1'b0},  // R3 private, user
    {4'd3, 1'b0, 2'd3, 20'h08000, 1'b0, 1'b1},  // R3 private, privileged
    {4'd3, 1'b1, 2'd0, 20'h09FFC, 1'b1, 1'b0},  // R3 private end, user write
    {4'd3, 1'b0, 2'd0, 20'h0A000, 1'b0, 1'b1},  // R3 just past private
    {4'd7, 1'b1, 2'd0, 20'h80100, 1'b0, 1'b0},  // R7 read-only reg write
    {4'd8, 1'b1, 2'd0, 20'h80000, 1'b0, 1'b1},  // R8 writable reg
    {4'd7, 1'b0, 2'd0, 20'h80104, 1'b0, 1'b1},  // R7 read-only reg read
    {4'd3, 1'b0, 2'd0, 20'h07FFC, 1'b0, 1'b1},  // R3 just below private
    {4'd7, 1'b1, 2'd3, 20'h80104, 1'b0, 1'b0}   // R7 privileged, still swallowed
  };

  task automatic expect_ok(input string req, input logic [1:0] tr, input logic [2:0] bu,
                           input logic [19:0] a, input logic [1:0] gap);
    logic e, f;
    logic [31:0] d;
    xfer(tr, 1'b0, bu, a, 2'd0, gap, e, d, f);
    check(req, {31'd0, e}, 32'd0);
    check(req, d, 32'(a) ^ MIX);
  endtask

  task automatic expect_err(input string req, input logic [1:0] tr, input logic [2:0] bu,
                            input logic [19:0] a, input logic [1:0] gap);
    logic e, f;
    logic [31:0] d;
    xfer(tr, 1'b0, bu, a, 2'd0, gap, e, d, f);
    check(req, {31'd0, e}, 32'd1);
    check(req, d, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic e, f;
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R9 reset ready", {31'd0, hreadyout}, 32'd1);
    check("R9 reset resp", {31'd0, hresp}, 32'd0);
    check("R8 reset idle", {30'd0, m_htrans}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", VEC[i][28:25], i);
      xfer(NSEQ, VEC[i][24], 3'd0, VEC[i][21:2], VEC[i][23:22], IDLE, e, d, f);
      check(tag, {31'd0, e}, {31'd0, VEC[i][1]});
      check(tag, {31'd0, f}, {31'd0, VEC[i][0]});
      if (VEC[i][1]) check("R6 zero data", d, 32'd0);
      else if (!VEC[i][24]) check(tag, d, 32'(VEC[i][21:2]) ^ MIX);
    end

    // R9 idle and busy answer OKAY
    @(negedge clk); hsel = 1'b1; htrans = BUSY;
    @(negedge clk); #1;
    check("R9 busy ready", {31'd0, hreadyout}, 32'd1);
    check("R9 busy resp", {31'd0, hresp}, 32'd0);
    htrans = IDLE;

    // R4 good INCR4 with BUSY gaps
    expect_ok("R4 incr4 b0", NSEQ, 3'd3, 20'h04000, BUSY);
    expect_ok("R4 incr4 b1", SEQ,  3'd3, 20'h04004, BUSY);
    expect_ok("R4 incr4 b2", SEQ,  3'd3, 20'h04008, BUSY);
    expect_ok("R4 incr4 b3", SEQ,  3'd3, 20'h0400C, IDLE);
    expect_ok("R4 after incr4", NSEQ, 3'd0, 20'h06000, IDLE);

    // R4 WRAP4 from mid-block
    expect_ok("R4 wrap4 b0", NSEQ, 3'd2, 20'h04008, BUSY);
    expect_ok("R4 wrap4 b1", SEQ,  3'd2, 20'h0400C, BUSY);
    expect_ok("R4 wrap4 b2", SEQ,  3'd2, 20'h04000, BUSY);
    expect_ok("R4 wrap4 b3", SEQ,  3'd2, 20'h04004, IDLE);

    // R4 address break
    expect_ok("R4 break b0", NSEQ, 3'd3, 20'h04000, BUSY);
    expect_err("R4 break b1", SEQ, 3'd3, 20'h04008, IDLE);
    expect_ok("R4 recover", NSEQ, 3'd0, 20'h06000, IDLE);

    // R5 cut by NONSEQ
    expect_ok("R5 cut b0", NSEQ, 3'd3, 20'h04000, BUSY);
    expect_ok("R5 cut b1", SEQ,  3'd3, 20'h04004, BUSY);
    expect_err("R5 cut by nonseq", NSEQ, 3'd0, 20'h06000, IDLE);
    expect_ok("R5 recover nonseq", NSEQ, 3'd0, 20'h06000, IDLE);

    // R5 cut by IDLE: next NONSEQ flagged
    expect_ok("R5 idle b0", NSEQ, 3'd5, 20'h04000, IDLE);
    expect_err("R5 cut by idle", NSEQ, 3'd0, 20'h06000, IDLE);
    expect_ok("R5 recover idle", NSEQ, 3'd0, 20'h06000, IDLE);

    // R5 undefined-length burst may stop anywhere
    expect_ok("R5 incr b0", NSEQ, 3'd1, 20'h04000, BUSY);
    expect_ok("R5 incr b1", SEQ,  3'd1, 20'h04004, IDLE);
    expect_ok("R5 incr end", NSEQ, 3'd0, 20'h06000, IDLE);

    // R2 configuration bits take effect
    cfg_rd = 4'b0000;
    expect_ok("R2 top sector open", NSEQ, 3'd0, 20'h0F000, IDLE);
    cfg_rd = 4'b1000;
    expect_ok("R2 sector 0 open", NSEQ, 3'd0, 20'h00000, IDLE);
    expect_err("R2 top sector only", NSEQ, 3'd0, 20'h0FFFC, IDLE);
    cfg_wr = 4'b0000;
    xfer(NSEQ, 1'b1, 3'd0, 20'h0E000, 2'd3, IDLE, e, d, f);
    check("R2 write bit clear", {30'd0, e, f}, 32'd1);

    finish_up();
  end
endmodule